// File: doc/BRIEF.md
# Receive Frame Ring with Word Read-Out

This block takes received Ethernet frames as a byte stream and parks each one in its own slot of a circular store. It holds a fixed number of slots, 31 by default. While bytes arrive, the block computes a CRC-32 over them one byte per cycle. When a frame ends, the block records a 16-bit length prefix and the 4-byte CRC trailer for that slot. It then bumps a pending-frame count and pulses a receive interrupt.

A host drains frames through one read strobe. Each strobe returns 32 bits of the oldest pending slot, little-endian. Once the slot's recorded length has been covered, the block moves on to the next slot. The order of bytes presented for a slot is: the length prefix, the frame bytes, the CRC, then zero fill up to the end of the word.

Frames that arrive while receive is disabled, or while every slot is occupied, are dropped whole. Frames longer than a slot can hold are cut short. A flush command empties the ring.

Top module: `rx_frame_ring`

## Requirements
- R1: After reset, `pending` is 0, `rd_data` is 0 and `rx_irq` is low.
- R2: An accepted frame raises `rx_irq` for one cycle, in the cycle after the cycle that presented its last byte. `pending` rises by one in the cycle after that.
- R3: A frame whose first byte arrives while `rx_enable` is low is dropped whole. It causes no interrupt and no change of `pending`.
- R4: A frame whose first byte arrives while SLOTS frames are held is dropped whole. A frame that is still committing counts as held.
- R5: Slot byte stream layout, where byte k of a word sits in `rd_data[8k+7:8k]`:
  - bytes 0 and 1 hold (payload bytes + 6), low byte first;
  - the payload follows;
  - then the CRC, least-significant byte first;
  - then zero bytes to the end of the last word.
- R6: The CRC is the reflected CRC-32 with polynomial 0xEDB88320. It starts from all ones, is inverted at the end, and covers the payload bytes only.
- R7: Payload bytes beyond SLOT_BYTES-6 are discarded. The length prefix and the CRC describe only the bytes that were kept.
- R8: Each strobe with frames pending advances the read offset by 4. When the offset reaches or passes the stored length, the offset returns to 0, the read slot moves to the next slot (wrapping from SLOTS-1 to 0) and `pending` drops by one.
- R9: A strobe with no frames pending returns 0 and changes nothing.
- R10: A `fifo_flush` cycle sets `pending` and the read offset to 0. It also discards a frame in progress or committing in that cycle. The next frame is read from its length prefix onwards.
- R11: Frames are read out in arrival order, including frames whose bytes follow each other with no idle cycle, and across slot wraparound.
- R12: `pending` never exceeds SLOTS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_valid | input | 1 | Receive byte present |
| rx_data | input | 8 | Receive byte |
| rx_last | input | 1 | Marks the final byte of a frame |
| rx_enable | input | 1 | Receive enable, sampled at the first byte of a frame |
| fifo_flush | input | 1 | Empties the ring |
| rd_strobe | input | 1 | Consumes the word currently on rd_data |
| rd_data | output | 32 | Current word of the oldest pending slot |
| pending | output | CNT_W | Number of frames held |
| rx_irq | output | 1 | One-cycle pulse per accepted frame |

## Verification
The bench builds the ring with 4 slots of 32 bytes, so the truncation limit is 26 payload bytes. A sweep of every payload size from 1 to 28 therefore covers all four zero-fill phases, the exact slot-filling length and two truncated sizes. The same sweep carries the read slot around the ring several times. With so few slots, filling the ring, dropping on full and dropping a frame that starts in the commit cycle of its predecessor each take only a handful of frames. Those cases are checked alongside flushes mid-read and mid-frame.

// File: rtl/rx_ring_pkg.sv
`timescale 1ns/1ps
// Shared types and the CRC step for the receive frame ring.
// Assumes reflected CRC-32 (poly 0xEDB88320), LSB of each byte first.
package rx_ring_pkg;

    localparam logic [31:0] CRC_POLY_REFL = 32'hEDB8_8320;

    // Per-slot record written when a frame commits
    typedef struct packed {
        logic [15:0] len;   // payload bytes + 6
        logic [31:0] crc;   // final (inverted) CRC
    } slot_meta_t;

    // Advance the CRC register by one byte
    function automatic logic [31:0] crc32_byte(input logic [31:0] c, input logic [7:0] d);
        logic [31:0] r;
        r = c;
        for (int b = 0; b < 8; b++) begin
            if (r[0] ^ d[b]) r = (r >> 1) ^ CRC_POLY_REFL;
            else             r = r >> 1;
        end
        return r;
    endfunction

endpackage

// File: rtl/rx_frame_writer.sv
`timescale 1ns/1ps
// Receive-side sequencer: decides at the first byte whether a frame is kept,
// stores kept payload bytes one per cycle, runs the CRC, and issues a
// one-cycle commit after the last byte.
// Assumes next_slot/ring_full already account for a frame committing now.
module rx_frame_writer
    import rx_ring_pkg::*;
#(
    parameter  int SLOTS      = 31,
    parameter  int SLOT_BYTES = 128,
    localparam int SLOT_W     = (SLOTS > 1) ? $clog2(SLOTS) : 1,
    localparam int POS_W      = $clog2(SLOT_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    input  logic              rx_last,
    input  logic              rx_enable,
    input  logic              flush,
    input  logic              ring_full,
    input  logic [SLOT_W-1:0] next_slot,
    output logic              mem_we,
    output logic [SLOT_W-1:0] mem_slot,
    output logic [POS_W-1:0]  mem_pos,
    output logic [7:0]        mem_byte,
    output logic              commit,
    output logic [SLOT_W-1:0] commit_slot,
    output logic [15:0]       commit_len,
    output logic [31:0]       commit_crc
);

    localparam int MAX_PAY = SLOT_BYTES - 6;

    logic              busy_q, keep_q, commit_q;
    logic [SLOT_W-1:0] slot_q;
    logic [POS_W-1:0]  cnt_q;
    logic [31:0]       crc_q;

    logic              first_c, keep_c, store_c;
    logic [SLOT_W-1:0] slot_c;
    logic [POS_W-1:0]  cnt_c;
    logic [31:0]       crc_c;

    // Select frame context: fresh at a first byte, carried otherwise
    always_comb begin
        first_c = !busy_q;
        keep_c  = (first_c ? (rx_enable && !ring_full) : keep_q) && !flush;
        slot_c  = first_c ? next_slot : slot_q;
        cnt_c   = first_c ? '0 : cnt_q;
        crc_c   = first_c ? '1 : crc_q;
        store_c = rx_valid && keep_c && (int'(cnt_c) < MAX_PAY);
    end

    // Track frame progress, CRC and the commit pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q   <= 1'b0;
            keep_q   <= 1'b0;
            commit_q <= 1'b0;
            slot_q   <= '0;
            cnt_q    <= '0;
            crc_q    <= '1;
        end else begin
            commit_q <= rx_valid && rx_last && keep_c;
            if (rx_valid) begin
                busy_q <= !rx_last;
                keep_q <= keep_c;
                slot_q <= slot_c;
                cnt_q  <= store_c ? cnt_c + POS_W'(1) : cnt_c;
                crc_q  <= store_c ? crc32_byte(crc_c, rx_data) : crc_c;
            end else if (flush) begin
                keep_q <= 1'b0;
            end
        end
    end

    assign mem_we      = store_c;
    assign mem_slot    = slot_c;
    assign mem_pos     = cnt_c + POS_W'(2);
    assign mem_byte    = rx_data;
    assign commit      = commit_q;
    assign commit_slot = slot_q;
    assign commit_len  = 16'(cnt_q) + 16'd6;
    assign commit_crc  = ~crc_q;

endmodule

// File: rtl/rx_byte_lanes.sv
`timescale 1ns/1ps
// Payload storage as four byte lanes, so a byte at slot position p lands in
// lane p[1:0] of word p/4 and a whole word reads out in one access.
// Assumes positions below SLOT_BYTES; asynchronous read.
module rx_byte_lanes #(
    parameter  int SLOTS      = 31,
    parameter  int SLOT_BYTES = 128,
    localparam int SLOT_W     = (SLOTS > 1) ? $clog2(SLOTS) : 1,
    localparam int POS_W      = $clog2(SLOT_BYTES),
    localparam int WORD_W     = POS_W - 2
) (
    input  logic              clk,
    input  logic              we,
    input  logic [SLOT_W-1:0] wr_slot,
    input  logic [POS_W-1:0]  wr_pos,
    input  logic [7:0]        wr_byte,
    input  logic [SLOT_W-1:0] rd_slot,
    input  logic [WORD_W-1:0] rd_word,
    output logic [31:0]       rd_data
);

    localparam int WORDS = SLOT_BYTES / 4;
    localparam int DEPTH = SLOTS * WORDS;
    localparam int AW    = $clog2(DEPTH);

    logic [AW-1:0] waddr, raddr;

    // Flatten slot/word into a lane address
    always_comb begin
        waddr = AW'(int'(wr_slot) * WORDS + int'(wr_pos[POS_W-1:2]));
        raddr = AW'(int'(rd_slot) * WORDS + int'(rd_word));
    end

    for (genvar l = 0; l < 4; l++) begin : g_lane
        logic [7:0] mem [DEPTH];

        // Write this lane when the byte position selects it
        always_ff @(posedge clk) begin
            if (we && (wr_pos[1:0] == 2'(l))) mem[waddr] <= wr_byte;
        end

        assign rd_data[8*l +: 8] = mem[raddr];
    end

endmodule

// File: rtl/rx_word_compose.sv
`timescale 1ns/1ps
// Builds the 32-bit read word for a slot from its length prefix, stored
// payload word and CRC trailer, zero-filling past the recorded length.
// Assumes len >= 6 whenever present is high.
module rx_word_compose
    import rx_ring_pkg::*;
#(
    parameter int OFS_W = 8
) (
    input  logic [OFS_W-1:0] ofs,
    input  slot_meta_t       meta,
    input  logic [31:0]      mem_word,
    input  logic             present,
    output logic [31:0]      word
);

    // Pick the byte that belongs at slot position pos
    function automatic logic [7:0] pick(input int pos, input int lane,
                                        input slot_meta_t m, input logic [31:0] mw);
        int pay;
        pay = int'(m.len) - 6;
        if (pos == 0)                   return m.len[7:0];
        else if (pos == 1)              return m.len[15:8];
        else if (pos < 2 + pay)         return 8'(mw >> (8 * lane));
        else if (pos < int'(m.len))     return 8'(m.crc >> (8 * (pos - 2 - pay)));
        else                            return 8'h00;
    endfunction

    for (genvar l = 0; l < 4; l++) begin : g_byte
        assign word[8*l +: 8] = present ? pick(int'(ofs) + l, l, meta, mem_word) : 8'h00;
    end

endmodule

// File: rtl/rx_frame_ring.sv
`timescale 1ns/1ps
// Receive frame ring top: SLOTS slots of SLOT_BYTES each, written by the
// frame writer and drained one 32-bit word per read strobe.
// Assumes SLOT_BYTES is a power of two, at least 16.
module rx_frame_ring
    import rx_ring_pkg::*;
#(
    parameter  int SLOTS      = 31,
    parameter  int SLOT_BYTES = 128,
    localparam int CNT_W      = $clog2(SLOTS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_valid,
    input  logic [7:0]       rx_data,
    input  logic             rx_last,
    input  logic             rx_enable,
    input  logic             fifo_flush,
    input  logic             rd_strobe,
    output logic [31:0]      rd_data,
    output logic [CNT_W-1:0] pending,
    output logic             rx_irq
);

    localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;
    localparam int POS_W  = $clog2(SLOT_BYTES);
    localparam int WORD_W = POS_W - 2;
    localparam int OFS_W  = POS_W + 1;

    logic [SLOT_W-1:0] rd_slot_q;
    logic [OFS_W-1:0]  rd_ofs_q;
    logic [CNT_W-1:0]  pend_q;
    slot_meta_t        meta_q [SLOTS];

    logic              mem_we, commit, ring_full, rd_go, rd_done;
    logic [SLOT_W-1:0] mem_slot, commit_slot, next_slot;
    logic [POS_W-1:0]  mem_pos;
    logic [7:0]        mem_byte;
    logic [15:0]       commit_len;
    logic [31:0]       commit_crc, lane_word;
    logic [CNT_W:0]    occ;
    slot_meta_t        cur_meta;

    // Occupancy including a committing frame, and the slot a new frame takes
    always_comb begin
        int ws;
        occ       = {1'b0, pend_q} + (CNT_W+1)'(commit);
        ring_full = int'(occ) >= SLOTS;
        ws        = int'(rd_slot_q) + int'(occ);
        if (ws >= SLOTS) ws = ws - SLOTS;
        next_slot = SLOT_W'(ws);
    end

    // Decide whether this strobe reads and whether it finishes the slot
    always_comb begin
        cur_meta = meta_q[rd_slot_q];
        rd_go    = rd_strobe && (pend_q != '0);
        rd_done  = rd_go && ((int'(rd_ofs_q) + 4) >= int'(cur_meta.len));
    end

    rx_frame_writer #(.SLOTS(SLOTS), .SLOT_BYTES(SLOT_BYTES)) u_writer (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_valid   (rx_valid),
        .rx_data    (rx_data),
        .rx_last    (rx_last),
        .rx_enable  (rx_enable),
        .flush      (fifo_flush),
        .ring_full  (ring_full),
        .next_slot  (next_slot),
        .mem_we     (mem_we),
        .mem_slot   (mem_slot),
        .mem_pos    (mem_pos),
        .mem_byte   (mem_byte),
        .commit     (commit),
        .commit_slot(commit_slot),
        .commit_len (commit_len),
        .commit_crc (commit_crc)
    );

    rx_byte_lanes #(.SLOTS(SLOTS), .SLOT_BYTES(SLOT_BYTES)) u_lanes (
        .clk    (clk),
        .we     (mem_we),
        .wr_slot(mem_slot),
        .wr_pos (mem_pos),
        .wr_byte(mem_byte),
        .rd_slot(rd_slot_q),
        .rd_word(rd_ofs_q[POS_W-1:2]),
        .rd_data(lane_word)
    );

    rx_word_compose #(.OFS_W(OFS_W)) u_compose (
        .ofs     (rd_ofs_q),
        .meta    (cur_meta),
        .mem_word(lane_word),
        .present (pend_q != '0),
        .word    (rd_data)
    );

    // Record length and CRC of a committing frame
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SLOTS; s++) meta_q[s] <= '0;
        end else if (commit && !fifo_flush) begin
            meta_q[commit_slot] <= '{len: commit_len, crc: commit_crc};
        end
    end

    // Read pointer, offset and pending count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_slot_q <= '0;
            rd_ofs_q  <= '0;
            pend_q    <= '0;
        end else if (fifo_flush) begin
            rd_ofs_q  <= '0;
            pend_q    <= '0;
        end else begin
            if (rd_done) begin
                rd_ofs_q  <= '0;
                rd_slot_q <= (int'(rd_slot_q) == SLOTS - 1) ? '0 : rd_slot_q + SLOT_W'(1);
            end else if (rd_go) begin
                rd_ofs_q  <= rd_ofs_q + OFS_W'(4);
            end
            pend_q <= pend_q + CNT_W'(commit) - CNT_W'(rd_done);
        end
    end

    assign pending = pend_q;
    assign rx_irq  = commit && !fifo_flush;

endmodule

// File: rtl/rx_frame_ring_chk.sv
`timescale 1ns/1ps
// Port-level properties of the receive frame ring, bound to the top module.
module rx_frame_ring_chk #(
    parameter int SLOTS = 31,
    parameter int CNT_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             fifo_flush,
    input logic             rx_irq,
    input logic [CNT_W-1:0] pending,
    input logic [31:0]      rd_data
);

    p_bound_r12: assert property (@(posedge clk) disable iff (!rst_n)
        int'(pending) <= SLOTS);

    p_irq_counts_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |=> pending != '0);

    p_empty_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pending == '0 |-> rd_data == 32'h0);

    p_flush_empties_r10: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_flush |=> pending == '0);

endmodule

bind rx_frame_ring rx_frame_ring_chk #(.SLOTS(SLOTS), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .fifo_flush(fifo_flush),
    .rx_irq    (rx_irq),
    .pending   (pending),
    .rd_data   (rd_data)
);

// File: tb/test_rx_frame_ring.sv
`timescale 1ns/1ps
module test_rx_frame_ring;

    localparam int SL   = 4;
    localparam int SB   = 32;
    localparam int MAXP = SB - 6;
    localparam int CW   = $clog2(SL + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rx_valid = 1'b0, rx_last = 1'b0, rx_enable = 1'b0;
    logic          fifo_flush = 1'b0, rd_strobe = 1'b0;
    logic [7:0]    rx_data = 8'h00;
    logic [31:0]   rd_data;
    logic [CW-1:0] pending;
    logic          rx_irq;

    int checks = 0, errors = 0, irq_cnt = 0;
    int q_len[$];
    int q_seed[$];

    always #2.5 clk = ~clk;

    rx_frame_ring #(.SLOTS(SL), .SLOT_BYTES(SB)) i_rx_frame_ring (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_last(rx_last), .rx_enable(rx_enable), .fifo_flush(fifo_flush),
        .rd_strobe(rd_strobe), .rd_data(rd_data), .pending(pending), .rx_irq(rx_irq)
    );

    always @(posedge clk) if (rst_n && rx_irq) irq_cnt++;

    function automatic logic [7:0] pay_byte(int seed, int i);
        return 8'((seed * 29 + i * 11 + 3) & 255);
    endfunction

    function automatic logic [31:0] ref_crc(int seed, int n);
        logic [31:0] c = 32'hFFFF_FFFF;
        for (int i = 0; i < n; i++) begin
            c = c ^ {24'h0, pay_byte(seed, i)};
            for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 32'hEDB8_8320) : (c >> 1);
        end
        return ~c;
    endfunction

    // Expected word w of a slot holding n payload bytes (R5, R6)
    function automatic logic [31:0] exp_word(int n, int seed, int w);
        logic [31:0] r = 0;
        logic [31:0] c = ref_crc(seed, n);
        int L = n + 6;
        for (int b = 0; b < 4; b++) begin
            int k = 4 * w + b;
            logic [7:0] v;
            if (k < 2)          v = 8'(L >> (8 * k));
            else if (k < 2 + n) v = pay_byte(seed, k - 2);
            else if (k < L)     v = 8'(c >> (8 * (k - 2 - n)));
            else                v = 8'h00;
            r[8*b +: 8] = v;
        end
        return r;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle(int k);
        repeat (k) begin
            @(negedge clk);
            rx_valid = 0; rx_last = 0; fifo_flush = 0;
        end
    endtask

    // Drive a frame; flush_at >= 0 pulses fifo_flush with that byte
    task automatic send(int n, int seed, bit gap, int flush_at);
        if (flush_at >= 0) begin
            q_len.delete(); q_seed.delete();
        end else if (rx_enable && q_len.size() < SL) begin
            q_len.push_back(n < MAXP ? n : MAXP);
            q_seed.push_back(seed);
        end
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (gap && i == 2) begin
                rx_valid = 0; fifo_flush = 0;
                @(negedge clk);
            end
            rx_valid = 1; rx_data = pay_byte(seed, i); rx_last = (i == n - 1);
            fifo_flush = (i == flush_at);
        end
    endtask

    task automatic drain_one(string req);
        int n = q_len.pop_front();
        int seed = q_seed.pop_front();
        int nw = (n + 6 + 3) / 4;
        for (int w = 0; w < nw; w++) begin
            @(negedge clk); rd_strobe = 1; #0.5;
            chk(req, rd_data, exp_word(n, seed, w));
        end
        @(negedge clk); rd_strobe = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int i0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk); #0.5;
        chk("R1 pending", 32'(pending), 0);
        chk("R1 rd_data", rd_data, 0);
        chk("R1 irq", 32'(irq_cnt), 0);

        // R9: empty read returns zero, changes nothing
        rx_enable = 1;
        @(negedge clk); rd_strobe = 1; #0.5;
        chk("R9 empty data", rd_data, 0);
        @(negedge clk); rd_strobe = 0; #0.5;
        chk("R9 empty pending", 32'(pending), 0);

        // R2: interrupt and count timing
        i0 = irq_cnt;
        send(5, 7, 0, -1);
        @(negedge clk); rx_valid = 0; rx_last = 0; #0.5;
        chk("R2 irq high", 32'(rx_irq), 1);
        chk("R2 pending not yet", 32'(pending), 0);
        @(negedge clk); #0.5;
        chk("R2 irq low", 32'(rx_irq), 0);
        chk("R2 pending", 32'(pending), 1);
        chk("R2 irq count", 32'(irq_cnt - i0), 1);
        drain_one("R5 R9 first word after empty read");
        #0.5 chk("R8 pending after drain", 32'(pending), 0);

        // R5 R6 R7 R8: every size, slot wrap
        for (int n = 1; n <= MAXP + 2; n++) begin
            send(n, n * 3, 0, -1);
            idle(2);
            drain_one(n > MAXP ? "R7 truncated frame" : "R5 R6 R8 sweep");
            #0.5 chk("R8 pending", 32'(pending), 0);
        end

        // R4 R11 R12: back-to-back fill, fifth dropped
        i0 = irq_cnt;
        for (int f = 0; f < SL + 1; f++) send(3 + f, 40 + f, 0, -1);
        idle(3); #0.5;
        chk("R4 R12 full count", 32'(pending), SL);
        chk("R4 irq count", 32'(irq_cnt - i0), SL);
        for (int f = 0; f < SL; f++) drain_one("R11 order");
        #0.5 chk("R11 drained", 32'(pending), 0);

        // R3: disabled receive
        rx_enable = 0; i0 = irq_cnt;
        send(9, 77, 0, -1);
        idle(3); #0.5;
        chk("R3 pending", 32'(pending), 0);
        chk("R3 irq", 32'(irq_cnt - i0), 0);
        rx_enable = 1;

        // R5: frame with idle gap
        send(11, 90, 1, -1);
        idle(3);
        drain_one("R5 gapped frame");

        // R10: flush mid-read
        send(6, 101, 0, -1);
        send(9, 102, 0, -1);
        idle(3);
        @(negedge clk); rd_strobe = 1; #0.5;
        chk("R10 pre-flush word", rd_data, exp_word(6, 101, 0));
        @(negedge clk); rd_strobe = 0; fifo_flush = 1;
        @(negedge clk); fifo_flush = 0; #0.5;
        chk("R10 pending", 32'(pending), 0);
        chk("R10 data", rd_data, 0);
        q_len.delete(); q_seed.delete();
        send(13, 103, 0, -1);
        idle(3); #0.5;
        chk("R10 one frame", 32'(pending), 1);
        drain_one("R10 read from prefix");

        // R10: flush mid-frame discards it
        i0 = irq_cnt;
        send(10, 110, 0, 4);
        idle(3); #0.5;
        chk("R10 aborted pending", 32'(pending), 0);
        chk("R10 aborted irq", 32'(irq_cnt - i0), 0);
        send(4, 111, 0, -1);
        idle(3);
        drain_one("R10 R11 after abort");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule